// File: doc/BRIEF.md
# Key-Protected Reset and Grouping Control Register

This block is a single 32-bit control word that sits on a simple memory-mapped write/read path inside a processor's system control space. Software can change it only by supplying a fixed 16-bit unlock key in the upper half of the written word. A write whose key does not match is dropped in its entirety.

The register stores a 3-bit priority-grouping value. The interrupt priority logic elsewhere in the chip receives that value on a dedicated output, so it can split priorities into preemption and sub-priority parts. The same write can also request a system reset or a vector reset. Each request leaves the block as a single-cycle pulse and is never stored.

A read returns a fixed identification pattern in the upper half, the endianness of the system, and the current grouping value. Endianness is a tie-off set by a parameter. The reset sequencing that consumes the pulses lies outside this block.

Top module: `reset_group_ctl`

## Requirements
- R1: After synchronous reset the grouping value is 0 and both reset-request outputs are low.
- R2: A write with bits 31:16 equal to 0x05FA is accepted, and the grouping value on the following cycle equals the written bits 10:8 (any of 0 to 7).
- R3: A write with any other value in bits 31:16 is discarded: the grouping value and both request outputs are unaffected.
- R4: An accepted write with bit 2 set drives `sys_rst_req` high for exactly the one cycle after the write; it is low otherwise.
- R5: An accepted write with bit 0 set drives `vec_rst_req` high for exactly the one cycle after the write; it is low otherwise.
- R6: The read word holds 0xFA05 in bits 31:16, the endianness tie-off in bit 15 and the grouping value in bits 10:8. Every other bit, including bits 2 and 0, reads as 0.
- R7: `grp_out` always equals the grouping value that the read word reports.
- R8: An accepted reset-request write that carries the current grouping value leaves the grouping value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register |
| bus_wdata | input | 32 | Write data, including the key in bits 31:16 |
| bus_rdata | output | 32 | Current read value of the register |
| grp_out | output | 3 | Priority-grouping value for the priority logic |
| sys_rst_req | output | 1 | One-cycle system reset request |
| vec_rst_req | output | 1 | One-cycle vector reset request |

## Verification
The bench builds the block with `ENDIAN_BIG` set to 1 and not with the default 0. With that value, bit 15 of the read word carries a 1 that a stuck-at-zero or misplaced endianness bit cannot reproduce, so the placement of the tie-off becomes observable. The grouping width and key constants stay at their package values. With those values, the boundary codes 0 and 7, keys that differ from the unlock key by a single bit, and an all-ones write are all within reach.

// File: rtl/rgc_pkg.sv
package rgc_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int GRP_W   = 3;
    localparam int GRP_LSB = 8;
    localparam int SYS_BIT = 2;
    localparam int VEC_BIT = 0;
    localparam int END_BIT = 15;
    localparam int REQ_N   = 2;

    localparam logic [HALF_W-1:0] UNLOCK_KEY = 16'h05FA;
    localparam logic [HALF_W-1:0] READ_TAG   = 16'hFA05;

    typedef struct packed {
        logic             accept;
        logic [GRP_W-1:0] grp;
        logic             sys_req;
        logic             vec_req;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(logic wr, logic [WORD_W-1:0] w);
        wr_cmd_t c;
        c.accept  = wr && (w[WORD_W-1:HALF_W] == UNLOCK_KEY);
        c.grp     = w[GRP_LSB +: GRP_W];
        c.sys_req = w[SYS_BIT];
        c.vec_req = w[VEC_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_readback(logic endian, logic [GRP_W-1:0] grp);
        logic [WORD_W-1:0] r;
        r                    = '0;
        r[WORD_W-1:HALF_W]   = READ_TAG;
        r[END_BIT]           = endian;
        r[GRP_LSB +: GRP_W]  = grp;
        return r;
    endfunction

endpackage

// File: rtl/rgc_decode.sv
module rgc_decode
    import rgc_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output wr_cmd_t           cmd
);
    always_comb begin
        cmd = decode_write(wr_en, wdata);
    end
endmodule

// File: rtl/rgc_pulse.sv
module rgc_pulse #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] fire,
    output logic [LANES-1:0] pulse
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) pulse[i] <= 1'b0;
            else     pulse[i] <= fire[i];
        end
    end
endmodule

// File: rtl/rgc_readback.sv
module rgc_readback
    import rgc_pkg::*;
#(
    parameter bit ENDIAN_BIG = 1'b0
) (
    input  logic [GRP_W-1:0]  grp,
    output logic [WORD_W-1:0] rdata
);
    always_comb begin
        rdata = pack_readback(ENDIAN_BIG, grp);
    end
endmodule

// File: rtl/reset_group_ctl.sv
module reset_group_ctl
    import rgc_pkg::*;
#(
    parameter bit ENDIAN_BIG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [GRP_W-1:0]  grp_out,
    output logic              sys_rst_req,
    output logic              vec_rst_req
);
    wr_cmd_t          cmd;
    logic [GRP_W-1:0] grp_q;
    logic [REQ_N-1:0] req_fire;
    logic [REQ_N-1:0] req_pulse;

    rgc_decode u_decode (
        .wr_en (bus_wr),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    always_ff @(posedge clk) begin
        if (rst)             grp_q <= '0;
        else if (cmd.accept) grp_q <= cmd.grp;
    end

    assign req_fire = {cmd.accept && cmd.sys_req, cmd.accept && cmd.vec_req};

    rgc_pulse #(.LANES(REQ_N)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (req_fire),
        .pulse (req_pulse)
    );

    assign sys_rst_req = req_pulse[1];
    assign vec_rst_req = req_pulse[0];
    assign grp_out     = grp_q;

    rgc_readback #(.ENDIAN_BIG(ENDIAN_BIG)) u_readback (
        .grp   (grp_q),
        .rdata (bus_rdata)
    );

    // R2: accepted write loads bits 10:8
    p_grp_load_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata[31:16] == 16'h05FA) |=> (grp_out == $past(bus_wdata[10:8])));

    // R3: without an accepted write the grouping holds
    p_grp_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_wdata[31:16] == 16'h05FA) |=> $stable(grp_out));

    // R4: system request only after an accepted write with bit 2
    p_sys_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> $past(bus_wr && bus_wdata[31:16] == 16'h05FA && bus_wdata[2]));

    // R5: vector request only after an accepted write with bit 0
    p_vec_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        vec_rst_req |-> $past(bus_wr && bus_wdata[31:16] == 16'h05FA && bus_wdata[0]));

    // R6: fixed read-back tag and request bits read as zero
    p_rd_tag_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[31:16] == 16'hFA05) && !bus_rdata[2] && !bus_rdata[0]);

    // R7: exported grouping matches read word
    p_grp_export_r7: assert property (@(posedge clk) disable iff (rst)
        grp_out == bus_rdata[10:8]);

endmodule

// File: tb/test_reset_group_ctl.sv
module test_reset_group_ctl;
    localparam time CLK_PERIOD = 10ns;
    localparam bit  TB_ENDIAN  = 1'b1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  grp_out;
    logic        sys_rst_req;
    logic        vec_rst_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_group_ctl #(.ENDIAN_BIG(TB_ENDIAN)) i_reset_group_ctl (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .grp_out     (grp_out),
        .sys_rst_req (sys_rst_req),
        .vec_rst_req (vec_rst_req)
    );

    typedef struct {
        string       tag;
        logic [31:0] rdata;
        logic [2:0]  grp;
        logic        sys;
        logic        vec;
    } exp_t;

    exp_t       sb_q[$];
    int         n_checks = 0;
    int         n_fail   = 0;
    logic [2:0] model_grp = '0;
    bit         done = 0;

    function automatic logic [31:0] exp_rd(logic [2:0] g);
        return {16'hFA05, TB_ENDIAN, 4'b0000, g, 8'h00};
    endfunction

    task automatic push(string tag, logic s, logic v);
        exp_t e;
        e.tag = tag; e.rdata = exp_rd(model_grp); e.grp = model_grp; e.sys = s; e.vec = v;
        sb_q.push_back(e);
    endtask

    task automatic do_write(logic [31:0] w, string tag);
        logic acc;
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = w;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        acc = (w[31:16] == 16'h05FA);
        if (acc) model_grp = w[10:8];
        push(tag, acc & w[2], acc & w[0]);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        push(tag, 1'b0, 1'b0);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (bus_rdata !== e.rdata || grp_out !== e.grp ||
                    sys_rst_req !== e.sys || vec_rst_req !== e.vec) begin
                    n_fail++;
                    $display("FAIL %s: actual rd=%h grp=%0d sys=%b vec=%b expected rd=%h grp=%0d sys=%b vec=%b",
                             e.tag, bus_rdata, grp_out, sys_rst_req, vec_rst_req,
                             e.rdata, e.grp, e.sys, e.vec);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle("R1 reset state");
        do_write(32'h05FA_0500, "R2 R6 R7 load grp 5");
        do_write(32'h05FB_0205, "R3 key off by one bit");
        do_write(32'h0000_0305, "R3 zero key");
        do_write(32'hFA05_0605, "R3 read tag used as key");
        do_write(32'h05FA_0504, "R4 R8 sys req keeps grp");
        idle("R4 sys pulse ends");
        do_write(32'h05FA_0501, "R5 R8 vec req keeps grp");
        idle("R5 vec pulse ends");
        do_write(32'h05FA_0000, "R2 grp 0 boundary");
        do_write(32'h05FA_0700, "R2 grp 7 boundary");
        do_write(32'h05FA_FFFF, "R6 all ones with key");
        idle("R4 R5 pulses end after all ones");
        do_write(32'h05FA_0205, "R4 R5 both requests grp 2");
        do_write(32'h05FA_0204, "R4 back to back sys");
        idle("R3 idle holds grp");
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule